// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs the management side of a two-wire PHY management bus. A host supplies a port index, a 5-bit register number, a direction bit, 16 bits of write data and a single-cycle start strobe. The block turns these into one complete management frame on the data line, clocked by a management clock that it divides down from the system clock. Reads return 16 bits of data and a turnaround error flag. Every transaction ends with a one-cycle done pulse.

The PHY address is built from the port index. An offset input selects between the address equal to the port (ports 0..23 map to 0..23) and the port plus one (1..24). The data line is bidirectional. The block presents it as an output value, an output enable and a separate input, so the pad cell stays outside the block. The default divider gives a 1.25 MHz management clock from a 250 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: A frame's first 34 bit periods are driven with output enable high: 32 ones, then the start pattern 0 then 1.
- R2: Bit periods 34..35 carry the opcode. It is 0,1 for a write (`rd_i`=0) and 1,0 for a read (`rd_i`=1).
- R3: Bit periods 36..40 carry the PHY address, MSB first. The address is `port_i` when `offset_i`=0 and `port_i`+1 when `offset_i`=1. Bit periods 41..45 carry `reg_i`, MSB first.
- R4: On a write, bit periods 46..47 are driven as 1 then 0, and periods 48..63 carry `wdata_i`, MSB first. The enable stays high for all 64 periods.
- R5: On a read, the enable is low from bit period 46 through 63. The line is sampled on each rising MDC edge, and the 16 data bits (periods 48..63, MSB first) appear on `rdata_o` when done pulses. `rdata_o` does not change on writes.
- R6: `err_o` is updated with every done pulse and holds until the next one. It is 1 only for a read whose second turnaround bit (period 47) was sampled as 1.
- R7: `mdc_o` has a period of 2*HALF_DIV system clocks and is high for HALF_DIV of them. `mdio_o` and `mdio_oe_o` change only on the system edge where `mdc_o` rises.
- R8: `mdio_oe_o` is low whenever `busy_o` is low, so the idle line is undriven.
- R9: `busy_o` rises in the cycle after an accepted start and stays high until done. `done_o` is high for exactly one cycle, and in that cycle `busy_o` is already low.
- R10: A start strobe while `busy_o` is high has no effect. The frame in progress, its result and the count of done pulses are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| port_i | input | 5 | Port index |
| offset_i | input | 1 | Add one to port index for PHY address |
| reg_i | input | 5 | PHY register number |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data from the last read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | Turnaround error of last transaction |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The assertions assume that `mdio_i` is stable at each rising MDC edge. The bench PHY model changes `mdio_i` only at falling MDC edges, and it drives the line only during the bit periods in which the master's enable is low. The checks also assume that `port_i + offset_i` stays within 5 bits. Stimulus therefore draws ports from 0..23 and registers from the full 5-bit range. A start strobe is raised only while the host is idle, except in the one directed case that issues a second strobe in the middle of a frame on purpose.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int TA_POS    = PRE_LEN + 2 + 2 + 2 * ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int FRAME_LEN = DATA_POS + DATA_W;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHIFT
  } seq_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_MAX);
  assign rise_o = wrap && !mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_addr_map.sv
module mdio_addr_map #(
  parameter int PORT_W = 5,
  parameter int ADDR_W = 5
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic              offset_i,
  output logic [ADDR_W-1:0] phy_o
);
  assign phy_o = ADDR_W'(port_i) + ADDR_W'(offset_i);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(TA_POS + 1);
  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

  seq_state_e             state_q;
  logic [FRAME_LEN-1:0]   frame_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   rd_q;
  logic                   ta_bad_q;
  logic [DATA_W-1:0]      shift_q;
  logic [IDX_W-1:0]       idx_nxt;
  mdio_op_e               op;

  assign busy_o  = (state_q != ST_IDLE);
  assign idx_nxt = idx_q + 1'b1;
  assign op      = rd_i ? OP_READ : OP_WRITE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      frame_q   <= '0;
      idx_q     <= '0;
      rd_q      <= 1'b0;
      ta_bad_q  <= 1'b0;
      shift_q   <= '0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          frame_q  <= {{PRE_LEN{1'b1}}, 2'b01, op, phy_i, reg_i,
                       rd_i ? 2'b11 : 2'b10, rd_i ? {DATA_W{1'b1}} : wdata_i};
          rd_q     <= rd_i;
          ta_bad_q <= 1'b0;
          state_q  <= ST_ARM;
        end
        ST_ARM: if (tick_i) begin
          mdio_o    <= frame_q[FRAME_LEN-1];
          mdio_oe_o <= 1'b1;
          frame_q   <= frame_q << 1;
          idx_q     <= '0;
          state_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          // sample the bit that the PHY presented during the period now ending
          if (rd_q && idx_q == IDX_TA2) ta_bad_q <= mdio_i;
          if (rd_q && idx_q >= IDX_DAT) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
          if (idx_q == IDX_LAST) begin
            mdio_oe_o <= 1'b0;
            mdio_o    <= 1'b0;
            done_o    <= 1'b1;
            err_o     <= rd_q & ta_bad_q;
            if (rd_q) rdata_o <= {shift_q[DATA_W-2:0], mdio_i};
            state_q   <= ST_IDLE;
          end else begin
            mdio_o    <= frame_q[FRAME_LEN-1];
            mdio_oe_o <= !(rd_q && idx_nxt >= IDX_TA1);
            frame_q   <= frame_q << 1;
            idx_q     <= idx_nxt;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 100,
  parameter int PORT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              offset_i,
  input  logic [4:0]        reg_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  import mdio_pkg::*;

  logic              tick;
  logic [ADDR_W-1:0] phy_addr;

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mdc_o (mdc_o),
    .rise_o(tick)
  );

  mdio_addr_map #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_map (
    .port_i  (port_i),
    .offset_i(offset_i),
    .phy_o   (phy_addr)
  );

  mdio_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .start_i  (start_i),
    .rd_i     (rd_i),
    .phy_i    (phy_addr),
    .reg_i    (reg_i),
    .wdata_i  (wdata_i),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o
);
  a_r8_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);

  a_r7_oe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $rose(mdc_o));

  a_r7_data_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $rose(mdc_o));

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_err_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o));

  a_r5_rdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .rdata_o  (rdata_o)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rd = 1'b0, offset = 1'b0;
  logic [4:0]  port = '0, regn = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, done, err, mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd), .port_i(port),
    .offset_i(offset), .reg_i(regn), .wdata_i(wdata), .rdata_o(rdata),
    .busy_o(busy), .done_o(done), .err_o(err), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // PHY model: records the line at falling MDC, drives its read bits there
  bit          mon_en = 0, mon_started = 0, mon_rd = 0, mon_bad = 0;
  int          mon_k = 0;
  logic [15:0] mon_rdata = '0;
  logic [63:0] cap_bit, cap_oe;

  always @(negedge mdc) begin
    if (mon_en) begin
      if (!mon_started && mdio_oe) mon_started = 1;
      if (mon_started && mon_k < 64) begin
        cap_bit[63-mon_k] = mdio_out;
        cap_oe[63-mon_k]  = mdio_oe;
        if (mon_rd) begin
          if (mon_k == 47) mdio_in = mon_bad;
          else if (mon_k >= 48) mdio_in = mon_rdata[63-mon_k];
          else mdio_in = 1'b1;
        end
        mon_k++;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc++;

  function automatic logic [63:0] exp_frame(bit r, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, phy, rg,
            r ? 2'b00 : 2'b10, r ? 16'h0000 : wd};
  endfunction

  function automatic logic [63:0] exp_oe(bit r);
    return r ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic run_txn(input logic [4:0] p, input bit off, input logic [4:0] rg,
                         input bit r, input logic [15:0] wd, input logic [15:0] phy_rd,
                         input bit bad, input bit inject);
    logic [15:0] prev_rdata;
    logic [63:0] ef, eo;
    logic [4:0]  phy;
    int          w;
    int          ndone;
    prev_rdata = rdata;
    phy = p + {4'b0, off};
    ef = exp_frame(r, phy, rg, wd);
    eo = exp_oe(r);
    mon_started = 0; mon_k = 0; mon_rd = r; mon_bad = bad; mon_rdata = phy_rd;
    cap_bit = '0; cap_oe = '0; mon_en = 1;
    @(negedge clk);
    port = p; offset = off; regn = rg; rd = r; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    if (inject) begin
      repeat (40) @(negedge clk);
      port = ~p; regn = ~rg; rd = ~r; wdata = ~wd; offset = ~off; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 4000) begin
      if (!busy) begin
        chk(0, "R9", "busy dropped before done", 64'(busy), 64'd1);
        break;
      end
      @(negedge clk);
      w++;
    end
    chk(done === 1'b1, "R9", "done seen", 64'(done), 64'd1);
    chk(err === (r & bad), "R6", "err flag", 64'(err), 64'(r & bad));
    chk(rdata === (r ? phy_rd : prev_rdata), "R5", "read data",
        64'(rdata), 64'(r ? phy_rd : prev_rdata));
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
    chk(busy === 1'b0 && mdio_oe === 1'b0, "R8", "idle released",
        64'({busy, mdio_oe}), 64'd0);
    mon_en = 0;
    mdio_in = 1'b1;
    chk(cap_oe === eo, "R5", "enable pattern", cap_oe, eo);
    chk(cap_bit[63:30] === ef[63:30], "R1", "preamble+start", cap_bit, ef);
    chk(cap_bit[29:28] === ef[29:28], "R2", "opcode", 64'(cap_bit[29:28]), 64'(ef[29:28]));
    chk(cap_bit[27:18] === ef[27:18], "R3", "phy+reg addr",
        64'(cap_bit[27:18]), 64'(ef[27:18]));
    if (!r)
      chk(cap_bit[17:0] === ef[17:0], "R4", "turnaround+data",
          64'(cap_bit[17:0]), 64'(ef[17:0]));
    if (inject) begin
      ndone = 0;
      repeat (2 * HALF * 70) begin
        @(negedge clk);
        if (done || busy) ndone++;
      end
      chk(ndone == 0, "R10", "no second transaction", 64'(ndone), 64'd0);
    end
  endtask

  initial begin
    int t0, t1, t2;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && mdio_oe === 0 && mdc === 0, "R8", "reset state",
        64'({busy, done, mdio_oe, mdc}), 64'd0);
    rst_n = 1'b1;
    @(posedge mdc); t0 = cyc;
    @(negedge mdc); t1 = cyc;
    @(posedge mdc); t2 = cyc;
    chk(t2 - t0 == 2 * HALF, "R7", "mdc period", 64'(t2 - t0), 64'(2 * HALF));
    chk(t1 - t0 == HALF, "R7", "mdc high time", 64'(t1 - t0), 64'(HALF));
    // directed corners
    run_txn(5'd0, 1'b0, 5'd0, 1'b0, 16'h0000, 16'h0, 1'b0, 1'b0);
    run_txn(5'd23, 1'b1, 5'd31, 1'b1, 16'h0, 16'hFFFF, 1'b0, 1'b0);
    run_txn(5'd23, 1'b0, 5'd17, 1'b0, 16'hA5C3, 16'h0, 1'b0, 1'b0);
    run_txn(5'd7, 1'b1, 5'd2, 1'b1, 16'h0, 16'h1234, 1'b1, 1'b0);
    run_txn(5'd12, 1'b0, 5'd9, 1'b0, 16'hBEEF, 16'h0, 1'b0, 1'b0);
    run_txn(5'd3, 1'b0, 5'd4, 1'b1, 16'h0, 16'h8001, 1'b0, 1'b1);
    run_txn(5'd9, 1'b1, 5'd21, 1'b0, 16'h7E5A, 16'h0, 1'b0, 1'b1);
    // constrained random
    for (int i = 0; i < 10; i++) begin
      run_txn(5'($urandom_range(0, 23)), 1'($urandom), 5'($urandom), 1'($urandom),
              16'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0), 1'b0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule